// File: doc/BRIEF.md
# Video Serial-Bus Command Port

This block is the register front end a host uses to send short byte messages to video devices hanging off a two-wire serial control bus. The host opens a message by writing a word to the start register. That word carries the target device address in bits 15:8 and the first data byte in bits 7:0. Further bytes of the same message go to the continue register, one byte per write, taken from bits 7:0.

Each accepted byte leaves the block on a one-cycle strobe. The strobe carries the captured device address, the byte's position within its message and the byte itself. The serial bit engine that consumes the strobe lies outside this block.

Software watches a busy flag in the status word to pace itself. Every accepted byte raises the flag and arms a poll counter. The flag does not drop on a completion event. It drops only after a fixed number of status reads have been made.

Top module: `vsb_cmd_port`

## Requirements
- R1: After reset, no byte strobe is raised and a status read returns 0x0000_0000. A continue write made before any start write is sent with device address 0x00 and index 0.
- R2: A write to offset 0x360 raises `byteValid` for exactly one cycle, starting on the clock edge after the write. The strobe carries address = written bits 15:8, data = written bits 7:0 and index 0.
- R3: A write to offset 0x364 raises `byteValid` for one cycle, starting on the following edge. The strobe carries data = written bits 7:0, the address captured by the last start write, and an index one greater than that of the previous byte. Written bits 31:8 are ignored.
- R4: A start write that follows a message resets the index to 0 and replaces the device address.
- R5: Any accepted byte sets the busy flag, which is status bit 31, and arms a poll count of BUSY_POLLS (default 10). The next BUSY_POLLS status reads return busy set. The read after them returns busy clear, and busy then stays clear until another byte is accepted.
- R6: A byte accepted while polls are in progress reloads the full poll count.
- R7: A read of offset 0x364 always returns zero and does not change the poll count.
- R8: Every status bit other than bit 31 reads as zero, including the more-data bit 29.
- R9: Writes to any other offset produce no strobe and leave busy unchanged. Reads of any other offset return zero and do not consume a poll.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Synchronous reset, active low |
| wrEn | input | 1 | Register write strobe |
| rdEn | input | 1 | Register read strobe |
| regAddr | input | OFS_W | Register offset |
| wrData | input | 32 | Write data |
| rdData | output | 32 | Read data, valid in the cycle of rdEn |
| byteValid | output | 1 | One-cycle strobe for an accepted byte |
| byteAddr | output | 8 | Device address of the message |
| byteIdx | output | IDX_W | Position of the byte within its message |
| byteData | output | 8 | Message byte |

## Verification
The hardest state to reach from the ports is the busy flag at the exact point where its poll count runs out, particularly when a new byte arrives partway through the countdown. The stimulus reaches it by issuing a precise number of status polls after each accepted byte. Reads of unrelated offsets are interleaved with those polls, so the bench can show that only status reads count toward the limit. A fresh byte is injected mid-countdown, and the bench then counts the full number of busy reads again before expecting the clear.

// File: rtl/vsb_pkg.sv
package vsb_pkg;
  typedef struct packed {
    logic startWr;   // open message
    logic contWr;    // append byte
    logic statusRd;  // status poll
    logic contRd;    // read of append offset
  } ctlStrb_t;
endpackage

// File: rtl/vsb_ctrl.sv
module vsb_ctrl
  import vsb_pkg::*;
#(
  parameter int OFS_W = 12,
  parameter logic [OFS_W-1:0] START_OFS = 12'h360,
  parameter logic [OFS_W-1:0] CONT_OFS  = 12'h364
) (
  input  logic             wrEn,
  input  logic             rdEn,
  input  logic [OFS_W-1:0] regAddr,
  output ctlStrb_t         strb
);
  logic hitStart;
  logic hitCont;

  assign hitStart = (regAddr == START_OFS);
  assign hitCont  = (regAddr == CONT_OFS);

  always_comb begin
    strb          = '0;
    strb.startWr  = wrEn && hitStart;
    strb.contWr   = wrEn && hitCont;
    strb.statusRd = rdEn && hitStart && !wrEn;
    strb.contRd   = rdEn && hitCont;
  end
endmodule

// File: rtl/vsb_dpath.sv
module vsb_dpath
  import vsb_pkg::*;
#(
  parameter int IDX_W      = 8,
  parameter int BUSY_POLLS = 10
) (
  input  logic             clk,
  input  logic             rstN,
  input  ctlStrb_t         strb,
  input  logic [31:0]      wrData,
  output logic [31:0]      rdData,
  output logic             byteValid,
  output logic [7:0]       byteAddr,
  output logic [IDX_W-1:0] byteIdx,
  output logic [7:0]       byteData
);
  localparam int CNT_W = $clog2(BUSY_POLLS + 1);
  localparam logic [CNT_W-1:0] CNT_LOAD = CNT_W'(BUSY_POLLS);
  localparam int BUSY_BIT = 31;

  logic             accept;
  logic [IDX_W-1:0] msgCount;
  logic [7:0]       devAddrQ;
  logic [CNT_W-1:0] busyCnt;
  logic             busyQ;
  logic             busyRead;
  logic [31:0]      statusWord;

  assign accept = strb.startWr || strb.contWr;

  // message indexing and address capture
  always_ff @(posedge clk) begin
    if (!rstN) begin
      msgCount  <= '0;
      devAddrQ  <= '0;
      byteValid <= 1'b0;
      byteAddr  <= '0;
      byteIdx   <= '0;
      byteData  <= '0;
    end else begin
      byteValid <= accept;
      if (strb.startWr) begin
        devAddrQ <= wrData[15:8];
        msgCount <= IDX_W'(1);
        byteAddr <= wrData[15:8];
        byteIdx  <= '0;
        byteData <= wrData[7:0];
      end else if (strb.contWr) begin
        msgCount <= msgCount + 1'b1;
        byteAddr <= devAddrQ;
        byteIdx  <= msgCount;
        byteData <= wrData[7:0];
      end
    end
  end

  // busy flag cleared by counting status polls
  always_ff @(posedge clk) begin
    if (!rstN) begin
      busyCnt <= '0;
      busyQ   <= 1'b0;
    end else if (accept) begin
      busyCnt <= CNT_LOAD;
      busyQ   <= 1'b1;
    end else if (strb.statusRd) begin
      if (busyCnt == '0) busyQ <= 1'b0;
      else               busyCnt <= busyCnt - 1'b1;
    end
  end

  assign busyRead = busyQ && (busyCnt != '0);

  always_comb begin
    statusWord           = '0;
    statusWord[BUSY_BIT] = busyRead;
  end

  assign rdData = strb.statusRd ? statusWord : 32'h0;

  // assertions
  p_start_idx_r2: assert property (@(posedge clk) disable iff (!rstN)
    strb.startWr |=> (byteValid && byteIdx == '0 && byteAddr == $past(wrData[15:8])));

  p_cont_addr_r3: assert property (@(posedge clk) disable iff (!rstN)
    (strb.contWr && !strb.startWr) |=> (byteValid && byteAddr == $past(devAddrQ)));

  p_accept_busy_r5: assert property (@(posedge clk) disable iff (!rstN)
    accept |=> (busyQ && busyCnt == CNT_LOAD));

  p_idle_cnt_r5: assert property (@(posedge clk) disable iff (!rstN)
    !busyQ |-> (busyCnt == '0));

  p_poll_dec_r5: assert property (@(posedge clk) disable iff (!rstN)
    (strb.statusRd && !accept && busyCnt != '0) |=> (busyCnt == $past(busyCnt) - 1'b1));

  p_poll_clear_r5: assert property (@(posedge clk) disable iff (!rstN)
    (strb.statusRd && !accept && busyCnt == '0) |=> !busyQ);

  p_cont_read_zero_r7: assert property (@(posedge clk) disable iff (!rstN)
    strb.contRd |-> (rdData == 32'h0));

  p_status_bits_r8: assert property (@(posedge clk) disable iff (!rstN)
    strb.statusRd |-> (rdData[30:0] == '0));

  p_no_accept_r9: assert property (@(posedge clk) disable iff (!rstN)
    !accept |=> !byteValid);
endmodule

// File: rtl/vsb_cmd_port.sv
module vsb_cmd_port
  import vsb_pkg::*;
#(
  parameter int OFS_W      = 12,
  parameter int IDX_W      = 8,
  parameter int BUSY_POLLS = 10,
  parameter logic [OFS_W-1:0] START_OFS = 12'h360,
  parameter logic [OFS_W-1:0] CONT_OFS  = 12'h364
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             wrEn,
  input  logic             rdEn,
  input  logic [OFS_W-1:0] regAddr,
  input  logic [31:0]      wrData,
  output logic [31:0]      rdData,
  output logic             byteValid,
  output logic [7:0]       byteAddr,
  output logic [IDX_W-1:0] byteIdx,
  output logic [7:0]       byteData
);
  ctlStrb_t strb;

  vsb_ctrl #(
    .OFS_W(OFS_W), .START_OFS(START_OFS), .CONT_OFS(CONT_OFS)
  ) u_ctrl (
    .wrEn(wrEn), .rdEn(rdEn), .regAddr(regAddr), .strb(strb)
  );

  vsb_dpath #(
    .IDX_W(IDX_W), .BUSY_POLLS(BUSY_POLLS)
  ) u_dpath (
    .clk(clk), .rstN(rstN), .strb(strb), .wrData(wrData), .rdData(rdData),
    .byteValid(byteValid), .byteAddr(byteAddr), .byteIdx(byteIdx),
    .byteData(byteData)
  );
endmodule

// File: tb/tb_vsb_cmd_port.sv
module tb_vsb_cmd_port;
  localparam int OFS_W = 12;
  localparam int IDX_W = 8;
  localparam int POLLS = 10;

  logic             clk = 1'b0;
  logic             rstN = 1'b0;
  logic             wrEn = 1'b0;
  logic             rdEn = 1'b0;
  logic [OFS_W-1:0] regAddr = '0;
  logic [31:0]      wrData = '0;
  logic [31:0]      rdData;
  logic             byteValid;
  logic [7:0]       byteAddr;
  logic [IDX_W-1:0] byteIdx;
  logic [7:0]       byteData;

  int nChecks = 0;
  int nFails  = 0;
  bit done    = 1'b0;

  always #2 clk = ~clk;  // 250 MHz

  vsb_cmd_port dut (
    .clk(clk), .rstN(rstN), .wrEn(wrEn), .rdEn(rdEn), .regAddr(regAddr),
    .wrData(wrData), .rdData(rdData), .byteValid(byteValid),
    .byteAddr(byteAddr), .byteIdx(byteIdx), .byteData(byteData)
  );

  typedef struct packed {
    logic        isRd;
    logic [11:0] ofs;
    logic [31:0] wdat;
    logic        expV;
    logic [7:0]  expAddr;
    logic [7:0]  expIdx;
    logic [7:0]  expData;
    logic [31:0] expRd;
  } vec_t;

  localparam int NVEC = 9;
  localparam vec_t TBL [NVEC] = '{
    '{1'b1, 12'h360, 32'h0,         1'b0, 8'h00, 8'd0, 8'h00, 32'h0},  // R1
    '{1'b0, 12'h360, 32'h0000_4A11, 1'b1, 8'h4A, 8'd0, 8'h11, 32'h0},  // R2
    '{1'b0, 12'h364, 32'h0000_0077, 1'b1, 8'h4A, 8'd1, 8'h77, 32'h0},  // R3
    '{1'b0, 12'h364, 32'hFFFF_FF05, 1'b1, 8'h4A, 8'd2, 8'h05, 32'h0},  // R3
    '{1'b0, 12'h300, 32'h0000_1234, 1'b0, 8'h00, 8'd0, 8'h00, 32'h0},  // R9
    '{1'b1, 12'h364, 32'h0,         1'b0, 8'h00, 8'd0, 8'h00, 32'h0},  // R7
    '{1'b1, 12'h300, 32'h0,         1'b0, 8'h00, 8'd0, 8'h00, 32'h0},  // R9
    '{1'b0, 12'h360, 32'h0000_9C3E, 1'b1, 8'h9C, 8'd0, 8'h3E, 32'h0},  // R4
    '{1'b0, 12'h364, 32'h0000_0001, 1'b1, 8'h9C, 8'd1, 8'h01, 32'h0}   // R4
  };

  task automatic check(input bit ok, input string req, input logic [31:0] act,
                       input logic [31:0] exp);
    nChecks++;
    if (!ok) begin
      nFails++;
      $display("FAIL %s actual=%08h expected=%08h", req, act, exp);
    end
  endtask

  // one bus cycle; read data sampled before the edge, strobe after it
  task automatic access(input bit isRd, input logic [11:0] ofs, input logic [31:0] wd,
                        output logic [31:0] rd, output logic v);
    @(negedge clk);
    wrEn = !isRd; rdEn = isRd; regAddr = ofs; wrData = wd;
    #1 rd = rdData;
    @(negedge clk);
    wrEn = 1'b0; rdEn = 1'b0;
    v = byteValid;
  endtask

  task automatic poll(input logic [31:0] exp, input string req);
    logic [31:0] rd; logic v;
    access(1'b1, 12'h360, 32'h0, rd, v);
    check(rd == exp, req, rd, exp);
  endtask

  initial begin : watchdog
    repeat (20000) @(posedge clk);
    if (!done) begin
      nFails++; nChecks++;
      $display("FAIL watchdog expired");
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", nChecks, nFails);
      $finish;
    end
  end

  initial begin
    logic [31:0] rd; logic v;
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    check(byteValid == 1'b0, "R1 reset strobe", {31'b0, byteValid}, 32'h0);

    for (int i = 0; i < NVEC; i++) begin
      access(TBL[i].isRd, TBL[i].ofs, TBL[i].wdat, rd, v);
      if (TBL[i].isRd) check(rd == TBL[i].expRd, "R1/R7/R9 read", rd, TBL[i].expRd);
      check(v == TBL[i].expV, "R2/R3/R9 strobe", {31'b0, v}, {31'b0, TBL[i].expV});
      if (TBL[i].expV)
        check({byteAddr, byteIdx, byteData} == {TBL[i].expAddr, TBL[i].expIdx, TBL[i].expData},
              "R2/R3/R4 fields", {8'h0, byteAddr, byteIdx, byteData},
              {8'h0, TBL[i].expAddr, TBL[i].expIdx, TBL[i].expData});
      @(negedge clk);
      check(byteValid == 1'b0, "R2 single-cycle strobe", {31'b0, byteValid}, 32'h0);
    end

    // R5, R8: full poll sequence
    for (int i = 0; i < POLLS; i++) poll(32'h8000_0000, "R5 busy poll");
    poll(32'h0, "R5 busy clears");
    poll(32'h0, "R5 stays clear");

    // R6: reload mid-countdown; R9: other reads do not consume polls
    access(1'b0, 12'h364, 32'h0000_00AB, rd, v);
    check(v && byteIdx == 8'd2 && byteAddr == 8'h9C, "R3 third byte",
          {8'h0, byteAddr, byteIdx, 8'h0}, {8'h0, 8'h9C, 8'd2, 8'h0});
    for (int i = 0; i < 5; i++) poll(32'h8000_0000, "R6 first polls");
    access(1'b0, 12'h364, 32'h0000_00CD, rd, v);
    for (int i = 0; i < 5; i++) poll(32'h8000_0000, "R6 reloaded");
    for (int i = 0; i < 3; i++) begin
      access(1'b1, 12'h300, 32'h0, rd, v);
      check(rd == 32'h0, "R9 other read zero", rd, 32'h0);
    end
    access(1'b1, 12'h364, 32'h0, rd, v);
    check(rd == 32'h0, "R7 cont read zero", rd, 32'h0);
    for (int i = 0; i < 5; i++) poll(32'h8000_0000, "R6 R9 remaining polls");
    poll(32'h0, "R6 clears after full count");

    // R9: unrelated write while idle leaves busy clear
    access(1'b0, 12'h368, 32'h0000_FFFF, rd, v);
    check(v == 1'b0, "R9 no strobe", {31'b0, v}, 32'h0);
    poll(32'h0, "R9 busy unchanged");

    // R1: reset mid-message, then continue without start
    access(1'b0, 12'h364, 32'h0000_0042, rd, v);
    @(negedge clk); rstN = 1'b0;
    @(negedge clk); rstN = 1'b1;
    poll(32'h0, "R1 status after reset");
    access(1'b0, 12'h364, 32'h0000_0055, rd, v);
    check(v && byteAddr == 8'h00 && byteIdx == 8'd0 && byteData == 8'h55,
          "R1 cont after reset", {7'b0, v, byteAddr, byteIdx, byteData}, 32'h0100_0055);

    done = 1'b1;
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", nChecks, nFails);
    $finish;
  end
endmodule